// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block decides which pending interrupt request a small 8-bit microcontroller core services next. There are six request sources, two external inputs, three timers and a serial port. The core writes an enable register and a priority register. Each cycle the block combines the raw request flags and masks them with the enables. It then selects a winner: high-priority requests come before low-priority ones, and a fixed polling order settles ties within a level. When the core is in the final cycle of an instruction and nothing blocks acceptance, the block raises a one-cycle take pulse with the 16-bit vector of the winning source.

Two in-service bits record nesting, one per level. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine, and a request at a level already in service waits. A return-from-interrupt releases the highest active level. A return, or a write to either register, also holds off acceptance until one more instruction has completed. In the take cycle the block pulses a clear for the flag of the winning source, but only for the two external and two basic timer sources. The serial and timer 2 flags are left for software to clear.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable register reads 00h, the priority register reads 00h, both in-service bits are 0, and take_o, vector_o and flag_clr_o are 0.
- R2: A write strobe loads wr_data_i into its register at the next clock edge. On readback, enable bit 6 and priority bits 7:6 always read 0.
- R3: Source k (index in polling order: 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial, 5 timer 2) is eligible only when enable bit k and enable bit 7 (global) are both 1.
- R4: flag_i bits 0..3 are the flags of sources 0..3. Serial requests when flag_i[4] or flag_i[5] is set. Timer 2 requests when flag_i[6] or flag_i[7] is set.
- R5: Among eligible requests at the same level, the lowest source index wins.
- R6: Priority bit k = 1 puts source k at the high level. Any eligible high-level request beats every low-level request.
- R7: vector_o equals 0003h + 8*k for winner k during take_o, and is 0000h otherwise.
- R8: take_o is asserted only in a cycle with instr_last_i = 1.
- R9: No request is taken during an instruction in which reti_i, wr_en_i or wr_prio_i was asserted. The earliest take is on the final cycle of the following instruction.
- R10: With the low level in service, only a high-level request is taken. With the high level in service, nothing is taken.
- R11: A take sets the in-service bit of the winner's level (in_svc_o[1] high, in_svc_o[0] low). reti_i clears in_svc_o[1] if it is set, otherwise in_svc_o[0].
- R12: In a take cycle flag_clr_o has bit k set when the winner k is 0..3, and it is 0 for serial or timer 2. Outside take cycles flag_clr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | 8 | Raw request flags (mapping in R4) |
| instr_last_i | input | 1 | Final cycle of the current instruction |
| reti_i | input | 1 | Current instruction is a return-from-interrupt |
| wr_en_i | input | 1 | Write strobe for the enable register |
| wr_prio_i | input | 1 | Write strobe for the priority register |
| wr_data_i | input | 8 | Write data |
| take_o | output | 1 | One-cycle request to vector |
| vector_o | output | 16 | Service routine address |
| flag_clr_o | output | 8 | Hardware clear for raw flags, valid with take_o |
| ien_o | output | 8 | Enable register readback |
| iprio_o | output | 8 | Priority register readback |
| in_svc_o | output | 2 | In-service bits, [1] high level, [0] low level |

## Verification
The selection logic is driven with single flags, which show that each source maps to the right vector and clear bit. It is driven with several flags at one level, which separates the polling order from any other tie-break. It is driven with mixed priority settings, which show that level outranks polling order. Nesting runs cover preemption of a low routine, refusal during a high routine, and release order on return. These runs distinguish a one-level release from a full clear. Writes and returns issued mid-instruction and on the final cycle check that the hold-off lasts exactly one further instruction. A long stretch of random flags, strobes and register contents is compared against the reference model every cycle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NSRC    = 6;
  localparam int NHWCLR  = 4;
  localparam int NFLAG   = 2 * NSRC - NHWCLR;
  localparam int IDXW    = $clog2(NSRC);
  localparam int VW      = 16;
  localparam int DW      = 8;
  localparam int GEN_BIT = DW - 1;
  localparam logic [VW-1:0] VEC_BASE = 16'h0003;
  localparam int VEC_SHIFT = 3;

  typedef struct packed {
    logic            found;
    logic [IDXW-1:0] idx;
  } pick_t;

  function automatic logic [VW-1:0] vec_of(input logic [IDXW-1:0] idx);
    logic [VW-1:0] ext;
    ext = VW'(idx);
    return VEC_BASE + (ext << VEC_SHIFT);
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_prio_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] ien_o,
  output logic [DW-1:0] iprio_o
);
  localparam logic [DW-1:0] SRC_MASK  = DW'((1 << NSRC) - 1);
  localparam logic [DW-1:0] EN_MASK   = SRC_MASK | DW'(1 << GEN_BIT);
  localparam logic [DW-1:0] PRIO_MASK = SRC_MASK;

  logic [DW-1:0] en_q, pr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      pr_q <= '0;
    end else begin
      if (wr_en_i)   en_q <= wr_data_i & EN_MASK;
      if (wr_prio_i) pr_q <= wr_data_i & PRIO_MASK;
    end
  end

  assign ien_o   = en_q;
  assign iprio_o = pr_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctl_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req_i,
  output pick_t        pick_o
);
  // lowest index wins
  always_comb begin
    pick_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        pick_o.found = 1'b1;
        pick_o.idx   = IDXW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_svc.sv
module irq_svc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       take_hi_i,
  input  logic       reti_i,
  input  logic       reg_wr_i,
  input  logic       instr_last_i,
  output logic [1:0] svc_o,
  output logic       hold_o
);
  logic [1:0] svc_q;
  logic       hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q  <= 2'b00;
      hold_q <= 1'b0;
    end else begin
      if (take_i) begin
        svc_q[take_hi_i] <= 1'b1;
      end else if (reti_i) begin
        if (svc_q[1]) svc_q[1] <= 1'b0;
        else          svc_q[0] <= 1'b0;
      end
      // hold-off lasts until the end of the blocking instruction
      hold_q <= instr_last_i ? 1'b0 : (hold_q | reti_i | reg_wr_i);
    end
  end

  assign svc_o  = svc_q;
  assign hold_o = hold_q | reti_i | reg_wr_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] flag_i,
  input  logic             instr_last_i,
  input  logic             reti_i,
  input  logic             wr_en_i,
  input  logic             wr_prio_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             take_o,
  output logic [VW-1:0]    vector_o,
  output logic [NFLAG-1:0] flag_clr_o,
  output logic [DW-1:0]    ien_o,
  output logic [DW-1:0]    iprio_o,
  output logic [1:0]       in_svc_o
);
  logic [NSRC-1:0] src, elig;
  logic [NSRC-1:0] lvl_req [2];
  pick_t           lvl_pick [2];
  pick_t           win;
  logic            win_hi, blocked;
  logic [1:0]      svc;

  irq_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_prio_i, .wr_data_i,
    .ien_o, .iprio_o
  );

  // raw flags to sources: shared flags ORed pairwise
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k < NHWCLR) begin : g_one
      assign src[k] = flag_i[k];
    end else begin : g_two
      assign src[k] = flag_i[2*k-NHWCLR] | flag_i[2*k-NHWCLR+1];
    end
  end

  assign elig = src & ien_o[NSRC-1:0] & {NSRC{ien_o[GEN_BIT]}};

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    if (l == 1) begin : g_hi
      assign lvl_req[l] = elig & iprio_o[NSRC-1:0];
    end else begin : g_lo
      assign lvl_req[l] = elig & ~iprio_o[NSRC-1:0];
    end
    irq_pick #(.N(NSRC)) u_pick (.req_i(lvl_req[l]), .pick_o(lvl_pick[l]));
  end

  always_comb begin
    win    = '0;
    win_hi = 1'b0;
    if (lvl_pick[1].found && !svc[1]) begin
      win    = lvl_pick[1];
      win_hi = 1'b1;
    end else if (lvl_pick[0].found && svc == 2'b00) begin
      win    = lvl_pick[0];
    end
  end

  irq_svc u_svc (
    .clk_i, .rst_ni,
    .take_i      (take_o),
    .take_hi_i   (win_hi),
    .reti_i,
    .reg_wr_i    (wr_en_i | wr_prio_i),
    .instr_last_i,
    .svc_o       (svc),
    .hold_o      (blocked)
  );

  assign take_o   = instr_last_i & ~blocked & win.found;
  assign vector_o = take_o ? vec_of(win.idx) : '0;
  assign in_svc_o = svc;

  for (genvar j = 0; j < NFLAG; j++) begin : g_clr
    if (j < NHWCLR) begin : g_hw
      assign flag_clr_o[j] = take_o && (win.idx == IDXW'(j));
    end else begin : g_sw
      assign flag_clr_o[j] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_ctl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_last_i,
  input logic             reti_i,
  input logic             wr_en_i,
  input logic             wr_prio_i,
  input logic             take_o,
  input logic [VW-1:0]    vector_o,
  input logic [NFLAG-1:0] flag_clr_o,
  input logic [DW-1:0]    ien_o,
  input logic [1:0]       in_svc_o
);
  p_take_on_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> instr_last_i);

  p_no_take_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i || wr_en_i || wr_prio_i) |-> !take_o);

  p_global_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_o[GEN_BIT] |-> !take_o);

  p_high_not_preempted_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o[1] |-> !take_o);

  p_vec_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> vector_o == '0);

  p_vec_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> vector_o[2:0] == 3'b011);

  p_clr_in_take_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> flag_clr_o == '0);

  p_clr_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_clr_o));

  p_take_nests_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> $countones(in_svc_o) == $countones($past(in_svc_o)) + 1);

  p_reti_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && in_svc_o != 2'b00) |=> $countones(in_svc_o) == $countones($past(in_svc_o)) - 1);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i, .rst_ni, .instr_last_i, .reti_i, .wr_en_i, .wr_prio_i,
  .take_o, .vector_o, .flag_clr_o, .ien_o, .in_svc_o
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  flag_i = '0;
  logic        instr_last_i = 1'b0, reti_i = 1'b0, wr_en_i = 1'b0, wr_prio_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        take_o;
  logic [15:0] vector_o;
  logic [7:0]  flag_clr_o, ien_o, iprio_o;
  logic [1:0]  in_svc_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_en = '0, m_pr = '0;
  logic [1:0] m_svc = '0;
  logic       m_hold = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_prio_ctrl dut (.*);

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic last, input logic reti, input logic we, input logic wp,
                      input logic [7:0] d, input logic [7:0] fl, input string tag);
    logic [5:0] src;
    bit found, hi, etake;
    int win;
    logic [15:0] evec;
    logic [7:0] eclr;
    @(negedge clk_i);
    instr_last_i = last; reti_i = reti; wr_en_i = we; wr_prio_i = wp;
    wr_data_i = d; flag_i = fl;
    #2;
    src = {fl[6] | fl[7], fl[4] | fl[5], fl[3:0]};
    found = 0; hi = 0; win = 0;
    if (!m_svc[1])
      for (int k = 0; k < 6; k++)
        if (!found && src[k] && m_en[k] && m_en[7] && m_pr[k]) begin found = 1; hi = 1; win = k; end
    if (!found && m_svc == 2'b00)
      for (int k = 0; k < 6; k++)
        if (!found && src[k] && m_en[k] && m_en[7] && !m_pr[k]) begin found = 1; win = k; end
    etake = last && !(m_hold || reti || we || wp) && found;
    evec  = etake ? 16'h0003 + 16'(8 * win) : 16'h0000;
    eclr  = (etake && win < 4) ? 8'(1 << win) : 8'h00;
    chk(tag, "take", 16'(take_o), 16'(etake));
    chk(tag, "vector", vector_o, evec);
    chk(tag, "flag_clr", 16'(flag_clr_o), 16'(eclr));
    chk(tag, "ien", 16'(ien_o), 16'(m_en));
    chk(tag, "iprio", 16'(iprio_o), 16'(m_pr));
    chk(tag, "in_svc", 16'(in_svc_o), 16'(m_svc));
    // advance model to the coming edge
    if (we) m_en = d & 8'hBF;
    if (wp) m_pr = d & 8'h3F;
    if (etake) m_svc[hi] = 1'b1;
    else if (reti) begin
      if (m_svc[1]) m_svc[1] = 1'b0;
      else          m_svc[0] = 1'b0;
    end
    m_hold = last ? 1'b0 : (m_hold | reti | we | wp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    step(0, 0, 0, 0, 8'h00, 8'h00, "R1");
    step(1, 0, 1, 0, 8'hFF, 8'h00, "R2");
    step(1, 0, 0, 1, 8'hFF, 8'h00, "R2");
    step(1, 0, 0, 0, 8'h00, 8'h00, "R2");
    step(1, 0, 0, 1, 8'h00, 8'h00, "R2");
    step(1, 0, 1, 0, 8'h01, 8'h00, "R3");
    step(1, 0, 0, 0, 8'h00, 8'h01, "R3");   // no global enable
    step(1, 0, 1, 0, 8'h81, 8'h01, "R9");   // write blocks
    step(0, 0, 0, 0, 8'h00, 8'h01, "R8");   // not final cycle
    step(1, 0, 0, 0, 8'h00, 8'h01, "R8");   // ext0 taken, 0003h
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(1, 0, 1, 0, 8'hBF, 8'h00, "R4");
    step(1, 0, 0, 0, 8'h00, 8'h20, "R4");   // serial tx, 0023h
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(1, 0, 0, 0, 8'h00, 8'h80, "R12");  // timer2 reload, no clear
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(1, 0, 0, 0, 8'h00, 8'h0E, "R5");   // tmr0 wins
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(1, 0, 0, 1, 8'h08, 8'h00, "R6");
    step(1, 0, 0, 0, 8'h00, 8'h0F, "R6");   // tmr1 high over ext0
    step(1, 0, 0, 0, 8'h00, 8'h0F, "R10");  // high in service
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(1, 0, 0, 0, 8'h00, 8'h01, "R10");  // low ext0
    step(1, 0, 0, 0, 8'h00, 8'h09, "R10");  // high preempts
    step(1, 0, 0, 0, 8'h00, 8'h01, "R10");
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");  // releases high only
    step(1, 0, 0, 0, 8'h00, 8'h04, "R10");  // equal level waits
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(1, 0, 0, 0, 8'h00, 8'h04, "R7");   // 0013h
    step(1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(0, 0, 0, 1, 8'h08, 8'h02, "R9");   // mid-instruction write
    step(1, 0, 0, 0, 8'h00, 8'h02, "R9");   // still blocked
    step(1, 0, 0, 0, 8'h00, 8'h02, "R9");   // now 000Bh
    step(0, 1, 0, 0, 8'h00, 8'h00, "R9");
    step(1, 0, 0, 0, 8'h00, 8'h02, "R9");
    step(1, 0, 0, 0, 8'h00, 8'h02, "R9");
    for (int i = 0; i < 600; i++) begin
      logic r, e, p;
      r = ($urandom % 8) == 0;
      e = ($urandom % 16) == 0;
      p = ($urandom % 16) == 0;
      step(($urandom % 3) != 0, r, e, p, 8'($urandom | 32'h80),
           8'($urandom & $urandom), "R5 R6 R10 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule